// File: doc/BRIEF.md
# Direct-mapped write-through byte cache

This block sits between a processor port and a main-memory port and keeps recently used 4-byte blocks close to the processor. Each memory block has exactly one home line, chosen by the line-index bits of its byte address. A read that finds a valid line with a matching tag is answered in the same cycle, and memory is not touched. A read that misses fetches the whole block from memory into its home line, replacing whatever was there. The next cycle then serves the request out of the refilled line.

Every write goes to memory. When the written block is already cached, the cached byte is updated at the same clock edge that completes the memory write. When it is not cached, no line is claimed. Only one request is in flight at a time. The processor holds its request steady until it sees ready. The memory port holds its request steady until memory answers, and memory may take any number of cycles to do so. The index width is a parameter: `IDX_W = 14` gives the full 64 KB arrangement, with an 8-bit tag, a 14-bit index and a 2-bit offset inside a 24-bit address. The default is kept smaller so the storage stays modest.

Top module: `dmc_cache`

## Requirements
- R1: A byte address is decoded as offset = bits [1:0], line index = the next IDX_W bits, and tag = all remaining upper bits. Two addresses that differ only in the tag share one line, and a block can live only in its home line.
- R2: A read whose line is valid and whose tag matches raises cpu_ready in the same cycle as the request, returns the addressed byte on cpu_rdata, and leaves mem_req low.
- R3: A read miss issues one memory read (mem_we = 0) of the block-aligned address, with mem_addr[1:0] = 0. The byte at offset k is carried on mem_rdata[8k+7:8k]. The line takes the block and the new tag at the handshake edge. cpu_ready rises in the following cycle with the requested byte.
- R4: A fill always overwrites its home line, so a later read of the block that was there before misses again.
- R5: Every write issues one memory write carrying the full byte address and data on mem_addr and mem_wdata, with mem_we = 1. cpu_ready is high in the same cycle as the mem_ready of that write.
- R6: A write to a cached block updates the cached byte, so a following read hits and returns the new value.
- R7: A write to an uncached block claims no line, so a following read of that block misses and fetches the written value from memory.
- R8: Reset invalidates every line, so the first read of any address after reset misses.
- R9: Once raised, mem_req stays high with mem_addr, mem_we and mem_wdata unchanged until mem_ready is seen.
- R10: cpu_ready is never high without cpu_req, and no new memory request starts until the current one completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until cpu_ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | 8 | Write byte |
| cpu_rdata | output | 8 | Read byte, valid while cpu_ready is high on a read |
| cpu_ready | output | 1 | Request completes at this clock edge |
| mem_req | output | 1 | Memory request, held until mem_ready |
| mem_we | output | 1 | 1 = byte write, 0 = block read |
| mem_addr | output | ADDR_W | Byte address for writes, block-aligned for reads |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8<<OFS_W | Block returned by memory, byte k in lane k |
| mem_ready | input | 1 | Memory completes the request at this clock edge |

## Verification
Suppose a valid bit, a stored tag or a data byte inside the line store is wrong. This shows up at the ports on the next read that indexes that line. A stale valid bit or tag turns an expected miss into a same-cycle ready with no memory read, or the reverse, so the ready arrives a full memory round trip early or late. A wrong data byte surfaces as a mismatching cpu_rdata on a hit to that block. The bench therefore predicts, for every request, the exact cycle of cpu_ready, the number and kind of memory transactions, and the returned byte. It does this under several memory latencies and with deliberate index conflicts, so that a corrupted line is caught on its first reuse.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } dmc_state_e;

endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
  parameter int IDX_W = 9,
  parameter int TAG_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_q [LINES];

  // valid bits: cleared together by reset, set one at a time by fills
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx] <= wr_tag;
    end
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
  parameter int IDX_W = 9,
  parameter int OFS_W = 2
) (
  input  logic                  clk,
  input  logic [IDX_W-1:0]      rd_idx,
  output logic [(8<<OFS_W)-1:0] rd_block,
  input  logic                  fill_en,
  input  logic                  byte_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [OFS_W-1:0]      wr_ofs,
  input  logic [(8<<OFS_W)-1:0] fill_block,
  input  logic [7:0]            wr_byte
);
  localparam int LINES = 1 << IDX_W;
  localparam int LANES = 1 << OFS_W;

  // one byte-wide array per lane so a single byte can be written alone
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] lane_q [LINES];
    logic       lane_hit;

    assign lane_hit = byte_en && (int'(wr_ofs) == g);

    always_ff @(posedge clk) begin
      if (fill_en) begin
        lane_q[wr_idx] <= fill_block[g*8 +: 8];
      end else if (lane_hit) begin
        lane_q[wr_idx] <= wr_byte;
      end
    end

    assign rd_block[g*8 +: 8] = lane_q[rd_idx];
  end
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
  import dmc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_req,
  input  logic cpu_we,
  input  logic op_we,
  input  logic lookup_hit,
  input  logic mem_ready,
  output logic busy,
  output logic capture_en,
  output logic fill_en,
  output logic wr_done,
  output logic cpu_ready
);
  dmc_state_e st_q, st_d;

  assign busy       = (st_q == ST_BUSY);
  assign capture_en = !busy && cpu_req && (cpu_we || !lookup_hit);
  assign fill_en    = busy && mem_ready && !op_we;
  assign wr_done    = busy && mem_ready && op_we;
  assign cpu_ready  = (!busy && cpu_req && !cpu_we && lookup_hit) || wr_done;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (capture_en) st_d = ST_BUSY;
      ST_BUSY: if (mem_ready)  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/dmc_cache.sv
module dmc_cache
  import dmc_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int OFS_W  = 2,
  parameter int IDX_W  = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cpu_req,
  input  logic                  cpu_we,
  input  logic [ADDR_W-1:0]     cpu_addr,
  input  logic [7:0]            cpu_wdata,
  output logic [7:0]            cpu_rdata,
  output logic                  cpu_ready,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [7:0]            mem_wdata,
  input  logic [(8<<OFS_W)-1:0] mem_rdata,
  input  logic                  mem_ready
);
  localparam int TAG_W = ADDR_W - IDX_W - OFS_W;
  localparam int BLK_W = 8 << OFS_W;

  // address field helpers
  function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
    return a[OFS_W +: IDX_W];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic logic [OFS_W-1:0] ofs_of(input logic [ADDR_W-1:0] a);
    return a[OFS_W-1:0];
  endfunction

  function automatic logic [ADDR_W-1:0] block_base(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
  endfunction

  function automatic logic [7:0] lane_pick(input logic [BLK_W-1:0] blk,
                                           input logic [OFS_W-1:0] ofs);
    return blk[int'(ofs)*8 +: 8];
  endfunction

  // captured request for the memory transaction
  logic              op_we;
  logic [ADDR_W-1:0] op_addr;
  logic [7:0]        op_wdata;

  // internal events, named for the checker
  logic              busy;
  logic              capture_en;
  logic              fill_done;
  logic              wr_done;
  logic              wr_hit;
  logic              lookup_hit;
  logic [ADDR_W-1:0] look_addr;

  logic              line_valid;
  logic [TAG_W-1:0]  line_tag;
  logic [BLK_W-1:0]  line_block;

  assign look_addr  = busy ? op_addr : cpu_addr;
  assign lookup_hit = line_valid && (line_tag == tag_of(look_addr));
  assign wr_hit     = wr_done && lookup_hit;

  dmc_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_req    (cpu_req),
    .cpu_we     (cpu_we),
    .op_we      (op_we),
    .lookup_hit (lookup_hit),
    .mem_ready  (mem_ready),
    .busy       (busy),
    .capture_en (capture_en),
    .fill_en    (fill_done),
    .wr_done    (wr_done),
    .cpu_ready  (cpu_ready)
  );

  dmc_tag_store #(
    .IDX_W (IDX_W),
    .TAG_W (TAG_W)
  ) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (idx_of(look_addr)),
    .rd_valid (line_valid),
    .rd_tag   (line_tag),
    .wr_en    (fill_done),
    .wr_idx   (idx_of(op_addr)),
    .wr_tag   (tag_of(op_addr))
  );

  dmc_data_store #(
    .IDX_W (IDX_W),
    .OFS_W (OFS_W)
  ) u_data (
    .clk        (clk),
    .rd_idx     (idx_of(look_addr)),
    .rd_block   (line_block),
    .fill_en    (fill_done),
    .byte_en    (wr_hit),
    .wr_idx     (idx_of(op_addr)),
    .wr_ofs     (ofs_of(op_addr)),
    .fill_block (mem_rdata),
    .wr_byte    (op_wdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_we    <= 1'b0;
      op_addr  <= '0;
      op_wdata <= '0;
    end else if (capture_en) begin
      op_we    <= cpu_we;
      op_addr  <= cpu_addr;
      op_wdata <= cpu_wdata;
    end
  end

  assign cpu_rdata = lane_pick(line_block, ofs_of(cpu_addr));
  assign mem_req   = busy;
  assign mem_we    = op_we;
  assign mem_addr  = op_we ? op_addr : block_base(op_addr);
  assign mem_wdata = op_wdata;
endmodule

// File: rtl/dmc_cache_chk.sv
module dmc_cache_chk #(
  parameter int ADDR_W = 24,
  parameter int OFS_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req,
  input logic              cpu_we,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [7:0]        cpu_wdata,
  input logic              cpu_ready,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [7:0]        mem_wdata,
  input logic              mem_ready,
  input logic              lookup_hit,
  input logic              fill_done,
  input logic              wr_done
);
  // R2: a read completes without any memory traffic in that cycle
  a_r2_hit_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready && !cpu_we |-> !mem_req);

  // R3: block reads are aligned
  a_r3_fill_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we |-> mem_addr[OFS_W-1:0] == '0);

  // R3: a completed fill is followed by a hit on the held request
  a_r3_fill_then_hit: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done && cpu_req && !cpu_we |=>
      !(cpu_req && !cpu_we && $stable(cpu_addr)) || (cpu_ready && lookup_hit));

  // R5: a write finishes only together with its memory write
  a_r5_write_with_mem: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready && cpu_we |-> mem_req && mem_we && mem_ready && wr_done);

  // R5: the memory write carries the processor's address and byte
  a_r5_write_fields: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && cpu_req |-> mem_addr == cpu_addr && mem_wdata == cpu_wdata);

  // R9: memory request is held unchanged until answered
  a_r9_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=>
      mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R10: no ready without a request
  a_r10_ready_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> cpu_req);

  // R10: after a memory handshake the port goes idle for a cycle
  a_r10_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ready |=> !mem_req);
endmodule

bind dmc_cache dmc_cache_chk #(
  .ADDR_W (ADDR_W),
  .OFS_W  (OFS_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cpu_req    (cpu_req),
  .cpu_we     (cpu_we),
  .cpu_addr   (cpu_addr),
  .cpu_wdata  (cpu_wdata),
  .cpu_ready  (cpu_ready),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .mem_ready  (mem_ready),
  .lookup_hit (lookup_hit),
  .fill_done  (fill_done),
  .wr_done    (wr_done)
);

// File: tb/dmc_cache_tb.sv
module dmc_cache_tb;
  localparam int AW = 24;
  localparam int OW = 2;
  localparam int IW = 9;
  localparam int NL = 1 << IW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_req = 1'b0;
  logic          cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [7:0]    cpu_wdata = '0;
  logic [7:0]    cpu_rdata;
  logic          cpu_ready;
  logic          mem_req;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata;
  logic [31:0]   mem_rdata = '0;
  logic          mem_ready = 1'b0;

  always #2 clk = ~clk;

  dmc_cache #(.ADDR_W(AW), .OFS_W(OW), .IDX_W(IW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int got, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [7:0] mem_w [int];
  int lat_cfg  = 0;
  int wait_cnt = 0;
  int rd_cnt   = 0;
  int wr_cnt   = 0;
  int last_rd_addr = -1;
  int last_wr_addr = -1;
  int last_wr_data = -1;

  function automatic logic [7:0] mem_byte(input int a);
    if (mem_w.exists(a)) return mem_w[a];
    return 8'((a * 13) + ((a >>> 8) * 7) + 5);
  endfunction

  always @(negedge clk) begin
    int base;
    if (!mem_req) wait_cnt = 0;
    mem_ready = mem_req && (wait_cnt == lat_cfg);
    if (mem_req && !mem_ready) wait_cnt++;
    base = int'(mem_addr) & ~3;
    mem_rdata = {mem_byte(base + 3), mem_byte(base + 2),
                 mem_byte(base + 1), mem_byte(base)};
  end

  always @(posedge clk) begin
    if (rst_n && mem_req && mem_ready) begin
      if (mem_we) begin
        mem_w[int'(mem_addr)] = mem_wdata;
        wr_cnt++;
        last_wr_addr = int'(mem_addr);
        last_wr_data = int'(mem_wdata);
      end else begin
        rd_cnt++;
        last_rd_addr = int'(mem_addr);
      end
    end
  end

  // ---------------- cache reference ----------------
  bit mv [int];
  int mt [int];

  function automatic int idx_f(input int a);
    return (a >>> OW) % NL;
  endfunction

  function automatic int tag_f(input int a);
    return a >>> (OW + IW);
  endfunction

  function automatic bit model_hit(input int a);
    int i = idx_f(a);
    return mv.exists(i) && mt[i] == tag_f(a);
  endfunction

  // one request; returns whether the model predicted a hit
  task automatic do_op(input bit we, input int addr, input int wdata,
                       input string req, output bit was_hit);
    int exp_wait, exp_data, rd0, wr0, cyc;
    bit hit;
    hit = model_hit(addr);
    was_hit = hit;
    exp_data = int'(mem_byte(addr));
    exp_wait = we ? lat_cfg + 1 : (hit ? 0 : lat_cfg + 2);
    rd0 = rd_cnt;
    wr0 = wr_cnt;
    @(negedge clk);
    cpu_req   = 1'b1;
    cpu_we    = we;
    cpu_addr  = AW'(addr);
    cpu_wdata = 8'(wdata);
    cyc = 0;
    forever begin
      #1;
      if (cpu_ready) break;
      cyc++;
      if (cyc > lat_cfg + 20) break;
      @(negedge clk);
    end
    // compared every clock: ready must not rise before or after the predicted cycle
    check(cyc == exp_wait, req, "ready cycle", cyc, exp_wait);
    if (!we) begin
      check(int'(cpu_rdata) == exp_data, req, "read byte", int'(cpu_rdata), exp_data);
    end
    @(posedge clk);
    #1;
    if (we) begin
      check(wr_cnt == wr0 + 1 && rd_cnt == rd0, req, "one memory write",
            wr_cnt - wr0, 1);
      check(last_wr_addr == addr && last_wr_data == (wdata & 255), req,
            "write address", last_wr_addr, addr);
    end else if (hit) begin
      check(rd_cnt == rd0 && wr_cnt == wr0, req, "no memory traffic on hit",
            rd_cnt - rd0, 0);
    end else begin
      check(rd_cnt == rd0 + 1 && wr_cnt == wr0, req, "one block read",
            rd_cnt - rd0, 1);
      check(last_rd_addr == (addr & ~3), req, "aligned block address",
            last_rd_addr, addr & ~3);
      mv[idx_f(addr)] = 1'b1;
      mt[idx_f(addr)] = tag_f(addr);
    end
  endtask

  task automatic idle_port();
    @(negedge clk);
    cpu_req = 1'b0;
    cpu_we  = 1'b0;
  endtask

  task automatic apply_reset();
    @(negedge clk);
    cpu_req = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    mv.delete();
    mt.delete();
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit h;
    int lfsr;
    int a_addr, b_addr, c_addr;
    apply_reset();
    @(negedge clk);
    #1;
    check(cpu_ready == 1'b0, "R10", "ready idle after reset", int'(cpu_ready), 0);
    check(mem_req == 1'b0, "R8", "memory idle after reset", int'(mem_req), 0);

    a_addr = 24'h01_2345;
    b_addr = a_addr + NL * 4;   // R1: same index, different tag
    c_addr = 24'h00_0ab8;

    // R8 / R3: first read misses and fills
    lat_cfg = 2;
    do_op(0, a_addr, 0, "R3", h);
    check(h == 0, "R8", "first access predicted miss", int'(h), 0);
    // R2: same byte and neighbour byte hit
    do_op(0, a_addr, 0, "R2", h);
    do_op(0, a_addr ^ 1, 0, "R2", h);
    check(h == 1, "R2", "same block hit", int'(h), 1);
    // R1: next block maps to a different line
    lat_cfg = 0;
    do_op(0, a_addr + 4, 0, "R1", h);
    do_op(0, a_addr, 0, "R1", h);
    check(h == 1, "R1", "neighbour line left A intact", int'(h), 1);
    // R4: conflicting block evicts A
    lat_cfg = 3;
    do_op(0, b_addr, 0, "R4", h);
    do_op(0, a_addr, 0, "R4", h);
    check(h == 0, "R4", "evicted block misses", int'(h), 0);
    // R5 / R6: write hit updates line and memory
    lat_cfg = 1;
    do_op(1, a_addr ^ 2, 8'h5a, "R5", h);
    check(h == 1, "R6", "write was to cached block", int'(h), 1);
    do_op(0, a_addr ^ 2, 0, "R6", h);
    check(h == 1, "R6", "read after write hit stays hit", int'(h), 1);
    // R7: write miss does not allocate
    lat_cfg = 4;
    do_op(1, c_addr, 8'hc3, "R7", h);
    do_op(0, c_addr, 0, "R7", h);
    check(h == 0, "R7", "read after write miss misses", int'(h), 0);
    do_op(0, c_addr, 0, "R7", h);
    // R8: reset in mid-run invalidates
    apply_reset();
    lat_cfg = 1;
    do_op(0, c_addr, 0, "R8", h);
    check(h == 0, "R8", "miss after second reset", int'(h), 0);

    // mixed traffic on a small address pool to force hits and conflicts
    lfsr = 32'h1d2c3b4a;
    for (int n = 0; n < 300; n++) begin
      int t, i, o, adr;
      lfsr = (lfsr << 1) ^ (((lfsr >>> 31) & 1) != 0 ? 32'h04c11db7 : 0);
      t = (lfsr >>> 3) & 3;
      i = (lfsr >>> 7) & 3;
      o = (lfsr >>> 11) & 3;
      adr = (t << (OW + IW)) | (i << OW) | o;
      lat_cfg = (lfsr >>> 15) & 3;
      if (((lfsr >>> 19) & 7) < 2) do_op(1, adr, (lfsr >>> 21) & 255, "R5", h);
      else                         do_op(0, adr, 0, "R2", h);
    end
    idle_port();
    repeat (2) @(negedge clk);
    #1;
    check(mem_req == 1'b0, "R10", "memory idle at end", int'(mem_req), 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule